// File: doc/BRIEF.md
# Trap-Door Watchdog Timer

This block is a watchdog that supervises software through a countdown. One 32-bit configuration write loads three values at once: a 16-bit count, an 8-bit prescale divisor and an 8-bit grace period. Each pulse on the tick input advances the prescaler. The main count steps down by one each time the prescaler wraps. When the count has run out, the block gives a one-cycle timeout interrupt. It then reuses the same counter to time the grace period. If software does not reconfigure the watchdog before that period ends, the block raises a reset request. The request stays asserted until the block itself is reset.

The watchdog starts running straight out of reset, using reset-time values set by parameters. While it is still in that first, untouched state, software has one chance to switch it off through a separate disable strobe. Once disabled, the watchdog halts at the next prescaler wrap. A later configuration write restarts it. Any configuration write rearms the watchdog from scratch.

Top module: `wdog_guard`

## Requirements
- R1: After reset both outputs are low, and with no write the watchdog runs on its reset values: the interrupt follows tick number (RST_CNT+1)*(RST_PRE+1) and the reset request follows tick number (RST_CNT+RST_DLY+2)*(RST_PRE+1).
- R2: A configuration write sets the count from bits 15:0, the prescaler P from bits 23:16 and the grace period D from bits 31:24. With count N, the timeout interrupt follows the (N+1)*(P+1)-th tick after the write. Cycles with tickEn low do not advance the timer.
- R3: The timeout interrupt is high for exactly one clock cycle, and only once per arming.
- R4: The reset request rises on the (N+D+2)*(P+1)-th tick after the write, which is (D+1)*(P+1) ticks after the interrupt.
- R5: Once raised, the reset request holds until rstN is asserted. While it is held, ticks, configuration writes and disable strobes cause no interrupt and no change.
- R6: A disable strobe given before any configuration write since reset turns the watchdog off: no interrupt and no reset request follow, however many ticks arrive.
- R7: A disable strobe given after a configuration write is ignored, and the interrupt comes at the tick set by that write.
- R8: A configuration write restarts a watchdog that was switched off. A configuration write made during the grace period rearms it fully, so the interrupt fires again at the new timing. A configuration write in the same cycle as a disable strobe or a tick takes priority over both.

Both the interrupt and the reset request rise at the clock edge that samples the deciding tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base enable; one prescaler step per cycle it is high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration word: grace period, prescaler and count |
| trapWrEn | input | 1 | One-time disable strobe |
| timeoutIrq | output | 1 | One-cycle timeout interrupt pulse |
| resetReq | output | 1 | Sticky reset request |

## Verification
The hardest case to reach from the ports is a watchdog switched off while still in its reset-time state. The state it moves to when the prescaler wraps looks the same from outside as the disabled state. Behaviour that depends on the reset-time values would also take millions of ticks at the default parameters. The bench therefore overrides the reset-time count, prescaler and grace period with small values. It disables the watchdog before and after a configuration write, lets the prescaler wrap, and then shows that a write restarts counting at the exact tick. A sweep over small prescaler, count and grace-period values checks the interrupt and reset tick numbers arithmetically.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_INIT     = 2'd0,
    ST_DISABLED = 2'd1,
    ST_ENABLED  = 2'd2,
    ST_STOPPED  = 2'd3
  } wdogState_e;

  typedef struct packed {
    logic loadAll;   // reload all fields from the write data
    logic preRun;    // advance the prescaler this cycle
    logic cntDec;    // step the main counter down
    logic cntDelay;  // load the counter with the grace period
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int DLY_W = 8,
  parameter logic [CNT_W-1:0] RST_CNT = '1,
  parameter logic [PRE_W-1:0] RST_PRE = '1,
  parameter logic [DLY_W-1:0] RST_DLY = '1,
  localparam int CFG_W = CNT_W + PRE_W + DLY_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wdog_pkg::wdogStrobe_t  strobe,
  input  logic [CFG_W-1:0]       cfgData,
  output logic                   preZero,
  output logic                   cntZero
);
  localparam int PRE_LO = CNT_W;
  localparam int DLY_LO = CNT_W + PRE_W;

  logic [PRE_W-1:0] preLoad;
  logic [PRE_W-1:0] preCnt;
  logic [DLY_W-1:0] dlyLoad;
  logic [CNT_W-1:0] mainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preLoad <= RST_PRE;
      preCnt  <= RST_PRE;
      dlyLoad <= RST_DLY;
      mainCnt <= RST_CNT;
    end else if (strobe.loadAll) begin
      preLoad <= cfgData[PRE_LO +: PRE_W];
      preCnt  <= cfgData[PRE_LO +: PRE_W];
      dlyLoad <= cfgData[DLY_LO +: DLY_W];
      mainCnt <= cfgData[0 +: CNT_W];
    end else begin
      if (strobe.preRun)
        preCnt <= (preCnt == '0) ? preLoad : preCnt - 1'b1;
      if (strobe.cntDelay)
        mainCnt <= CNT_W'(dlyLoad);
      else if (strobe.cntDec)
        mainCnt <= mainCnt - 1'b1;
    end
  end

  assign preZero = (preCnt == '0);
  assign cntZero = (mainCnt == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickEn,
  input  logic                    cfgWrEn,
  input  logic                    trapWrEn,
  input  logic                    preZero,
  input  logic                    cntZero,
  output wdog_pkg::wdogStrobe_t   strobe,
  output wdog_pkg::wdogState_e    curState,
  output logic                    timeoutIrq,
  output logic                    resetReq
);
  import wdog_pkg::*;

  wdogState_e state;
  logic inDelay;
  logic counting, active, expire, fireReset;

  always_comb begin
    counting       = (state == ST_INIT) || (state == ST_ENABLED);
    active         = !resetReq && (counting || (state == ST_DISABLED));
    strobe.loadAll = cfgWrEn && !resetReq;
    strobe.preRun  = tickEn && active && !strobe.loadAll;
    expire         = strobe.preRun && preZero;
    strobe.cntDec  = expire && counting && !cntZero;
    strobe.cntDelay = expire && counting && cntZero && !inDelay;
    fireReset      = expire && counting && cntZero && inDelay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_INIT;
      inDelay    <= 1'b0;
      timeoutIrq <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      timeoutIrq <= strobe.cntDelay;
      if (strobe.loadAll) begin
        state   <= ST_ENABLED;
        inDelay <= 1'b0;
      end else begin
        if (trapWrEn && state == ST_INIT)
          state <= ST_DISABLED;
        else if (expire && state == ST_DISABLED)
          state <= ST_STOPPED;
        if (strobe.cntDelay)
          inDelay <= 1'b1;
      end
      if (fireReset)
        resetReq <= 1'b1;
    end
  end

  assign curState = state;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int DLY_W = 8,
  parameter logic [CNT_W-1:0] RST_CNT = '1,
  parameter logic [PRE_W-1:0] RST_PRE = '1,
  parameter logic [DLY_W-1:0] RST_DLY = '1,
  localparam int CFG_W = CNT_W + PRE_W + DLY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             trapWrEn,
  output logic             timeoutIrq,
  output logic             resetReq
);
  wdog_pkg::wdogStrobe_t strobe;
  wdog_pkg::wdogState_e  curState;
  logic preZero, cntZero;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgWrEn(cfgWrEn),
    .trapWrEn(trapWrEn), .preZero(preZero), .cntZero(cntZero),
    .strobe(strobe), .curState(curState),
    .timeoutIrq(timeoutIrq), .resetReq(resetReq)
  );

  wdog_dp #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .DLY_W(DLY_W),
    .RST_CNT(RST_CNT), .RST_PRE(RST_PRE), .RST_DLY(RST_DLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgWrData),
    .preZero(preZero), .cntZero(cntZero)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic                 cfgWrEn,
  input logic                 trapWrEn,
  input logic                 timeoutIrq,
  input logic                 resetReq,
  input wdog_pkg::wdogState_e curState
);
  import wdog_pkg::*;

  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |=> !timeoutIrq);

  assert_irq_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> $past(tickEn));

  assert_reset_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(tickEn));

  assert_reset_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);

  assert_off_no_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_DISABLED || curState == ST_STOPPED) && !cfgWrEn) |=> !timeoutIrq);

  assert_trap_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ENABLED && trapWrEn) |=> curState == ST_ENABLED);

  assert_write_enables_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !resetReq) |=> curState == ST_ENABLED);
endmodule

bind wdog_guard wdog_guard_chk u_chk (.*);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 3;
  localparam int RP = 1;
  localparam int RD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic trapWrEn = 1'b0;
  logic timeoutIrq, resetReq;

  int checks = 0;
  int failures = 0;
  int irqAt, rstAt, irqCount;
  bit pulseBad;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_guard #(.RST_CNT(16'(RC)), .RST_PRE(8'(RP)), .RST_DLY(8'(RD))) u_wdog_guard (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .trapWrEn(trapWrEn),
    .timeoutIrq(timeoutIrq), .resetReq(resetReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 0; cfgWrEn = 0; trapWrEn = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cfgWrite(input int d, input int p, input int n);
    cfgWrEn = 1'b1;
    cfgWrData = {8'(d), 8'(p), 16'(n)};
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic trapWrite();
    trapWrEn = 1'b1;
    @(negedge clk);
    trapWrEn = 1'b0;
  endtask

  task automatic runTicks(input int n, input int gap);
    irqAt = -1; rstAt = -1; irqCount = 0; pulseBad = 1'b0;
    for (int t = 1; t <= n; t++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      if (timeoutIrq) begin
        irqCount++;
        if (irqAt < 0) irqAt = t;
      end
      if (resetReq && rstAt < 0) rstAt = t;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (timeoutIrq) pulseBad = 1'b1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state and free run on reset values
    doReset();
    check("R1 irq after reset", int'(timeoutIrq), 0);
    check("R1 resetReq after reset", int'(resetReq), 0);
    runTicks(20, 1);
    check("R1 irq tick", irqAt, (RC + 1) * (RP + 1));
    check("R1 reset tick", rstAt, (RC + RD + 2) * (RP + 1));

    // R2 R3 R4: sweep of prescaler, count and grace period
    for (int p = 0; p <= 2; p++)
      for (int n = 0; n <= 3; n++)
        for (int d = 0; d <= 2; d++) begin
          doReset();
          cfgWrite(d, p, n);
          runTicks((n + d + 2) * (p + 1) + 3, 1);
          check("R2 irq tick", irqAt, (n + 1) * (p + 1));
          check("R3 irq count", irqCount, 1);
          check("R3 irq pulse width", int'(pulseBad), 0);
          check("R4 reset tick", rstAt, (n + d + 2) * (p + 1));
        end

    // R2: idle cycles between ticks do not advance
    doReset();
    cfgWrite(1, 2, 2);
    runTicks(20, 3);
    check("R2 irq tick with gaps", irqAt, 9);
    check("R4 reset tick with gaps", rstAt, 15);

    // R5: sticky reset request ignores writes and ticks
    cfgWrite(0, 0, 0);
    trapWrite();
    runTicks(10, 1);
    check("R5 resetReq held", int'(resetReq), 1);
    check("R5 no irq while held", irqCount, 0);
    doReset();
    check("R5 cleared by reset", int'(resetReq), 0);

    // R6: disable in the initial state
    trapWrite();
    runTicks(40, 1);
    check("R6 no irq when disabled", irqCount, 0);
    check("R6 no reset when disabled", rstAt, -1);

    // R7: disable strobe after a write is ignored
    doReset();
    cfgWrite(2, 0, 1);
    trapWrite();
    runTicks(8, 1);
    check("R7 irq tick kept", irqAt, 2);
    check("R7 reset tick kept", rstAt, 5);

    // R8: restart after disable, rearm during grace period, priority
    doReset();
    trapWrite();
    runTicks(10, 1);
    cfgWrite(0, 0, 2);
    runTicks(6, 1);
    check("R8 restart irq tick", irqAt, 3);
    check("R8 restart reset tick", rstAt, 4);

    doReset();
    cfgWrite(5, 0, 0);
    runTicks(2, 1);
    check("R8 first irq", irqAt, 1);
    cfgWrite(0, 0, 1);
    runTicks(5, 1);
    check("R8 rearmed irq tick", irqAt, 2);
    check("R8 rearmed reset tick", rstAt, 3);

    doReset();
    cfgWrEn = 1'b1; trapWrEn = 1'b1; tickEn = 1'b1;
    cfgWrData = {8'd0, 8'd0, 16'd1};
    @(negedge clk);
    cfgWrEn = 1'b0; trapWrEn = 1'b0; tickEn = 1'b0;
    runTicks(4, 1);
    check("R8 write beats trap and tick", irqAt, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule